// File: doc/BRIEF.md
# Paged Serial EEPROM Target on a Two-Wire Bus

This block is the target side of a two-wire serial bus (I2C). It stands in front of a small on-chip byte array and behaves like a serial EEPROM. The bus clock and data lines arrive as plain inputs sampled by the system clock. The block pulls the data line low through a single open-drain enable. It recognises Start and Stop conditions on the bus. It acknowledges its device address when the upper nibble holds the fixed family code and the next three bits equal its strap pins.

A write transfer carries a two-byte word address followed by data bytes. The data bytes are collected in a 64-byte page buffer and reach the array only when the master ends the transfer with a Stop. The array is then updated over a self-timed busy window, and the block ignores its own address until that window ends. A master can therefore poll for completion with repeated address bytes. Reads begin either at an address set by a dummy write (random read) or at the internal pointer (current-address read). They continue byte after byte for as long as the master acknowledges.

Top module: `i2c_page_eeprom`

## Requirements
- R1: A device address byte carries 1010 in bits 7..4, the strap value in bits 3..1 and the direction in bit 0 (1 = read). It is acknowledged only when both fields match. Otherwise the block leaves SDA released and ignores the bus until the next Start.
- R2: After a write-direction address, the first word-address byte supplies address bits 14..8 from its bits 6..0, and its bit 7 is ignored. The second byte supplies bits 7..0. The array decodes the low MEM_AW bits.
- R3: Each data byte of a write transfer is acknowledged on the ninth clock.
- R4: After each data byte only the low six bits of the pointer advance. Data past the end of a 64-byte page wraps to offset 0 of the same page and overwrites earlier bytes of that transfer.
- R5: The array changes only after a Stop, and only at the page offsets that received data. Other bytes of the page keep their contents.
- R6: If a Start arrives before the Stop of a write transfer, the buffered bytes are dropped and no busy window begins, so the next address byte is acknowledged.
- R7: A Stop that ends a transfer with buffered data opens a busy window of BUSY_CYCLES clocks. During that window the device address is not acknowledged. After the window it is acknowledged normally.
- R8: A read-direction address sends the byte at the pointer MSB first. The pointer then advances over the full array, and further bytes follow while the master acknowledges.
- R9: A read that has no preceding word address starts at the pointer left by the previous access.
- R10: After the master does not acknowledge a read byte, the block releases SDA and ends the transfer.
- R11: The SDA enable changes only while the synchronised SCL is low.
- R12: After reset SDA is released and the block waits for a Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Address strap pins compared with address bits 3..1 |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except to form Start and Stop. Each SCL phase is longer than the two-flop synchroniser plus the edge detector. A Start or Stop never arrives while the block is pulling SDA low. The bench drives SCL with eight-clock half periods and changes SDA four clocks into each low phase. It issues Start and Stop only when the block has released the line.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK
  } eep_state_e;

  typedef enum logic [1:0] {
    AFT_AHI, AFT_ALO, AFT_WDAT, AFT_READ
  } eep_after_e;

  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == DEV_FAMILY) && (b[3:1] == strap);
  endfunction

endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int MEM_AW      = 9,
  parameter int PAGE_AW     = 6,
  parameter int BUSY_CYCLES = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PAGE_AW-1:0]        wr_off,
  input  logic [7:0]                wr_data,
  input  logic [MEM_AW-PAGE_AW-1:0] wr_base,
  input  logic                      discard,
  input  logic                      commit_go,
  input  logic [MEM_AW-1:0]         rd_addr,
  output logic [7:0]                rd_data,
  output logic                      busy
);
  localparam int PAGE_N = 1 << PAGE_AW;
  localparam int MEM_N  = 1 << MEM_AW;
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);
  localparam int BASE_W = MEM_AW - PAGE_AW;

  logic [7:0]        pbuf [PAGE_N];
  logic [7:0]        mem  [MEM_N];
  logic [PAGE_N-1:0] vld;
  logic [BASE_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_AW:0]  idx;
  logic              pend;
  logic              do_copy;

  assign pend    = |vld;
  assign do_copy = busy && !idx[PAGE_AW] && vld[idx[PAGE_AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      vld    <= '0;
      base_q <= '0;
      cnt    <= '0;
      idx    <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (!idx[PAGE_AW]) idx <= idx + 1'b1;
      if (cnt == CNT_W'(BUSY_CYCLES - 1)) begin
        busy <= 1'b0;
        vld  <= '0;
      end
    end else if (commit_go && pend) begin
      busy <= 1'b1;
      cnt  <= '0;
      idx  <= '0;
    end else if (discard) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_off] <= 1'b1;
      base_q      <= wr_base;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !busy) pbuf[wr_off] <= wr_data;
    if (do_copy) mem[{base_q, idx[PAGE_AW-1:0]}] <= pbuf[idx[PAGE_AW-1:0]];
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_page_eeprom.sv
module i2c_page_eeprom #(
  parameter int MEM_AW      = 9,
  parameter int PAGE_AW     = 6,
  parameter int BUSY_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);
  import eep_pkg::*;

  localparam int BASE_W = MEM_AW - PAGE_AW;

  function automatic logic [MEM_AW-1:0] word_addr(input logic [6:0] hi, input logic [7:0] lo);
    return MEM_AW'({hi, lo});
  endfunction

  function automatic logic [MEM_AW-1:0] page_next(input logic [MEM_AW-1:0] p);
    return {p[MEM_AW-1:PAGE_AW], p[PAGE_AW-1:0] + 1'b1};
  endfunction

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, pg_wr, st_idle, byte_done;
  logic [7:0] rd_data, rx_sh, tx_sh;
  logic [6:0] ahi;
  logic [3:0] bit_cnt;
  logic [MEM_AW-1:0] ptr;
  logic mack;
  eep_state_e st;
  eep_after_e aft;

  eep_bus_sense u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign pg_wr     = !start_ev && !stop_ev && (st == ST_WDAT) && byte_done;
  assign st_idle   = (st == ST_IDLE);

  eep_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pg_wr), .wr_off(ptr[PAGE_AW-1:0]), .wr_data(rx_sh),
    .wr_base(ptr[MEM_AW-1:PAGE_AW]),
    .discard(start_ev && !busy), .commit_go(stop_ev),
    .rd_addr(ptr), .rd_data(rd_data), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      aft      <= AFT_AHI;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ahi      <= '0;
      ptr      <= '0;
      mack     <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_ev) begin
      st       <= ST_DEV;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_ev) begin
      st       <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (st == ST_DEV) begin
              if (dev_hit(rx_sh, strap_i) && !busy) begin
                sda_oe_o <= 1'b1;
                st       <= ST_ACK;
                aft      <= rx_sh[0] ? AFT_READ : AFT_AHI;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              sda_oe_o <= 1'b1;
              st       <= ST_ACK;
              if (st == ST_AHI) begin
                ahi <= rx_sh[6:0];
                aft <= AFT_ALO;
              end else if (st == ST_ALO) begin
                ptr <= word_addr(ahi, rx_sh);
                aft <= AFT_WDAT;
              end else begin
                ptr <= page_next(ptr);
                aft <= AFT_WDAT;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (aft == AFT_READ) begin
              tx_sh    <= rd_data;
              ptr      <= ptr + 1'b1;
              sda_oe_o <= ~rd_data[7];
              st       <= ST_RDAT;
            end else begin
              sda_oe_o <= 1'b0;
              st <= (aft == AFT_AHI) ? ST_AHI : (aft == AFT_ALO) ? ST_ALO : ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
              st       <= ST_RACK;
            end else begin
              bit_cnt  <= bit_cnt + 1'b1;
              tx_sh    <= {tx_sh[6:0], 1'b0};
              sda_oe_o <= ~tx_sh[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              tx_sh    <= rd_data;
              ptr      <= ptr + 1'b1;
              sda_oe_o <= ~rd_data[7];
              st       <= ST_RDAT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int MEM_AW  = 9,
  parameter int PAGE_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe_o,
  input logic              scl_s,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              busy,
  input logic              pg_wr,
  input logic              st_idle,
  input logic [MEM_AW-1:0] ptr
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s); // R11

  AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe_o); // R7

  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev)); // R5

  AST_START_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !$rose(busy)); // R6

  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr |=> (ptr[MEM_AW-1:PAGE_AW] == $past(ptr[MEM_AW-1:PAGE_AW])) &&
              (ptr[PAGE_AW-1:0] == PAGE_AW'($past(ptr[PAGE_AW-1:0]) + 1'b1))); // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe_o); // R10
endmodule

bind i2c_page_eeprom eep_chk #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .scl_s(scl_s),
  .start_ev(start_ev), .stop_ev(stop_ev), .busy(busy), .pg_wr(pg_wr),
  .st_idle(st_idle), .ptr(ptr)
);

// File: tb/test_i2c_page_eeprom.sv
module test_i2c_page_eeprom;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int r11_bad = 0;
  logic prev_oe = 1'b0;
  bit   done = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  always #2 clk = ~clk;

  i2c_page_eeprom i_i2c_page_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(4);
    scl_m = 1'b1; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    b = sda_line; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic send(input logic [7:0] v, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    chk(tag, {31'd0, ~a}, {31'd0, exp_ack});
  endtask

  // driver: pushes the expected byte, then clocks the byte in from the bus
  task automatic recv(input logic [7:0] exp, input logic last, input string tag);
    logic [7:0] v;
    logic b;
    v = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      v = {v[6:0], b};
    end
    put_bit(last);
    act_q.push_back(v);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    bus_start();
    send(DEV_W, 1'b1, tag);
    send(hi, 1'b1, tag);
    send(lo, 1'b1, tag);
  endtask

  // monitor: compares bytes as the bus produces them
  initial begin
    forever begin
      @(posedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {24'd0, a}, {24'd0, e});
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_m) r11_bad++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R12 reset release", {31'd0, sda_oe}, 32'd0);

    // R1: wrong strap and wrong family are not acknowledged
    bus_start();
    send(8'hA2, 1'b0, "R1 strap mismatch");
    bus_stop();
    bus_start();
    send(8'hBA, 1'b0, "R1 family mismatch");
    put_bit(1'b0);
    chk("R1 ignored after mismatch", {31'd0, sda_oe}, 32'd0);
    bus_stop();

    // R2/R3: write four bytes at 0x110 with the don't-care MSB set
    set_addr(8'h81, 8'h10, "R2 addr ack");
    send(8'h11, 1'b1, "R3 data ack");
    send(8'h22, 1'b1, "R3 data ack");
    send(8'h33, 1'b1, "R3 data ack");
    send(8'h44, 1'b1, "R3 data ack");
    bus_stop();

    // R7: poll during busy is refused, later accepted
    bus_start();
    send(DEV_W, 1'b0, "R7 nack while busy");
    bus_stop();
    tick(400);
    bus_start();
    send(DEV_W, 1'b1, "R7 ack after busy");
    bus_stop();

    // R8/R2: random read from 0x110 with MSB clear
    set_addr(8'h01, 8'h10, "R8 addr ack");
    bus_start();
    send(DEV_R, 1'b1, "R8 read addr ack");
    recv(8'h11, 1'b0, "R8 byte0");
    recv(8'h22, 1'b0, "R8 byte1");
    recv(8'h33, 1'b1, "R2 byte2");
    tick(4);
    chk("R10 released after nack", {31'd0, sda_oe}, 32'd0);
    bus_stop();

    // R9: current address read continues at 0x113
    bus_start();
    send(DEV_R, 1'b1, "R9 read ack");
    recv(8'h44, 1'b1, "R9 current byte");
    bus_stop();

    // R5 prefill 0x42
    set_addr(8'h00, 8'h42, "R5 prefill");
    send(8'hC2, 1'b1, "R5 prefill data");
    bus_stop();
    tick(400);

    // R4: write at 0x7E wraps to 0x40
    set_addr(8'h00, 8'h7E, "R4 addr");
    send(8'hB0, 1'b1, "R4 data");
    send(8'hB1, 1'b1, "R4 data");
    send(8'hB2, 1'b1, "R4 data");
    send(8'hB3, 1'b1, "R4 data");
    bus_stop();
    tick(400);
    set_addr(8'h00, 8'h7E, "R4 raddr");
    bus_start();
    send(DEV_R, 1'b1, "R4 read ack");
    recv(8'hB0, 1'b0, "R4 at 7E");
    recv(8'hB1, 1'b1, "R4 at 7F");
    bus_stop();
    set_addr(8'h00, 8'h40, "R4 raddr2");
    bus_start();
    send(DEV_R, 1'b1, "R4 read ack2");
    recv(8'hB2, 1'b0, "R4 wrapped 40");
    recv(8'hB3, 1'b0, "R4 wrapped 41");
    recv(8'hC2, 1'b1, "R5 untouched 42");
    bus_stop();

    // R4: 65 bytes into page 0xC0, the last one overwrites offset 0
    set_addr(8'h00, 8'hC0, "R4 long addr");
    for (int i = 0; i < 65; i++) send(8'(i), 1'b1, "R3 long data ack");
    bus_stop();
    tick(400);
    set_addr(8'h00, 8'hC0, "R4 long raddr");
    bus_start();
    send(DEV_R, 1'b1, "R4 long read ack");
    recv(8'h40, 1'b0, "R4 overwrite C0");
    recv(8'h01, 1'b1, "R4 kept C1");
    bus_stop();

    // R6: Start before Stop drops the byte, no busy window follows
    set_addr(8'h01, 8'h10, "R6 addr");
    send(8'hEE, 1'b1, "R6 data");
    bus_start();
    send(DEV_W, 1'b1, "R6 ack no busy");
    send(8'h01, 1'b1, "R6 hi");
    send(8'h10, 1'b1, "R6 lo");
    bus_start();
    send(DEV_R, 1'b1, "R6 read ack");
    recv(8'h11, 1'b1, "R6 old data kept");
    bus_stop();

    tick(40);
    chk("R11 oe only with scl low", r11_bad, 32'd0);
    chk("R8 scoreboard drained", act_q.size(), 32'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule